// File: doc/BRIEF.md
# Three-Phase Gate Pattern Generator with Dead-Time Insertion

This block turns three signed duty references, one per inverter leg, into six gate signals: a high-side and a low-side gate per leg. A single symmetric up/down carrier, shared by all legs, is compared with each leg's latched reference to form a high-side command. The low-side command is its complement. A per-leg state machine only lets a gate rise once its command has held steady for a fixed guard interval. Both switches of a leg therefore stay off through every changeover.

The default parameters assume a 100 MHz clock. With them, a carrier peak of 5000 counts gives a 10 kHz switching period, and a guard of 100 cycles gives 1 µs. The references are intended to be sinusoids 120 degrees apart, produced upstream. A reference is sampled only while the carrier sits at zero. A synchronous enable parks the carrier and forces every gate off. The carrier is parked at zero with direction up.

Carrier states: `CAR_UP` moves to `CAR_DOWN` when the count reaches the peak, and `CAR_DOWN` moves to `CAR_UP` when the count returns to zero. Any state returns to `CAR_UP` at zero while disabled. Leg states: `LEG_IDLE` goes to `LEG_GAP` when enabled. `LEG_GAP` goes to `LEG_HIGH` or `LEG_LOW` after the guard expires with the command unchanged. If the command flips, `LEG_GAP` restarts with the new aim. `LEG_HIGH` goes to `LEG_GAP` when the command drops, and `LEG_LOW` goes to `LEG_GAP` when the command rises. Every state goes to `LEG_IDLE` when disabled.

Top module: `pwm3_gate_gen`

## Requirements
- R1: During reset, all six gates are low. When `enable` is sampled low at a clock edge, all six gates are low from that edge on.
- R2: While enabled, the carrier steps by one count per clock as 0,1,…,PEAK,PEAK−1,…,1,0,1,… (period 2·PEAK). While disabled, it is held at 0 and resumes counting upward.
- R3: A leg's high-side command is true in a cycle exactly when 2·count < ref + PEAK. Here `ref` is the leg's latched reference, which is 0 after reset.
- R4: A duty input is latched at a clock edge only when the carrier count is 0. A change at any other time has no effect until the next zero.
- R5: Duty inputs above +PEAK are treated as +PEAK, and those below −PEAK as −PEAK.
- R6: The low-side gate of a leg follows the inverse of the high-side command, subject to R8.
- R7: The high-side and low-side gates of one leg are never high in the same cycle.
- R8: A gate is high after an edge only if, over the DEAD+1 cycles up to that edge, `enable` was high and its command held the value it asserts. Between one gate of a leg falling and the other rising, at least DEAD cycles have both low.
- R9: A command pulse shorter than DEAD+1 cycles asserts neither gate of that leg.
- R10: After `enable` returns high, no gate rises until the guard of R8 has run from the resume edge.
- R11: Each leg uses only its own duty input (`duty_a` drives index 0, `duty_b` drives index 1, `duty_c` drives index 2). All legs share one carrier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Synchronous run enable; low forces all gates off |
| duty_a | input | DUTY_W | Signed duty reference, leg 0 |
| duty_b | input | DUTY_W | Signed duty reference, leg 1 |
| duty_c | input | DUTY_W | Signed duty reference, leg 2 |
| gate_hi | output | 3 | High-side gates, bit i for leg i |
| gate_lo | output | 3 | Low-side gates, bit i for leg i |

## Verification
The properties take for granted that PEAK is representable in a DUTY_W-bit signed word and that DEAD is at least one. They also assume `enable` and the duty words are synchronous to `clk`, so that the carrier-step and latch-hold properties see clean values. The stimulus changes every input shortly after a rising edge. It holds reset for several edges before the first enable. It keeps duty words inside the signed range of the reduced-width build, while still reaching beyond ±PEAK to exercise the clamp.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

    localparam int NUM_LEGS = 3;

    typedef enum logic {
        CAR_UP,
        CAR_DOWN
    } car_dir_t;

    typedef enum logic [1:0] {
        LEG_IDLE,
        LEG_GAP,
        LEG_HIGH,
        LEG_LOW
    } leg_state_t;

endpackage

// File: rtl/pwm3_carrier.sv
module pwm3_carrier
    import pwm3_pkg::*;
#(
    parameter int PEAK = 5000,
    localparam int CW = $clog2(PEAK + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    output logic [CW-1:0] count,
    output logic          at_zero
);

    car_dir_t      dir_q, dir_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= CAR_UP;
            cnt_q <= '0;
        end else begin
            dir_q <= dir_d;
            cnt_q <= cnt_d;
        end
    end

    // next-state
    always_comb begin
        dir_d = dir_q;
        cnt_d = cnt_q;
        if (!enable) begin
            dir_d = CAR_UP;
            cnt_d = '0;
        end else begin
            unique case (dir_q)
                CAR_UP: begin
                    cnt_d = cnt_q + CW'(1);
                    if (cnt_q == CW'(PEAK - 1)) dir_d = CAR_DOWN;
                end
                CAR_DOWN: begin
                    cnt_d = cnt_q - CW'(1);
                    if (cnt_q == CW'(1)) dir_d = CAR_UP;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        count   = cnt_q;
        at_zero = (cnt_q == '0);
    end

endmodule

// File: rtl/pwm3_compare.sv
module pwm3_compare #(
    parameter int PEAK   = 5000,
    parameter int DUTY_W = 16,
    parameter int CW     = $clog2(PEAK + 1),
    localparam int EW    = ((DUTY_W > CW + 1) ? DUTY_W : CW + 1) + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     at_zero,
    input  logic [CW-1:0]            count,
    input  logic signed [DUTY_W-1:0] duty_in,
    output logic signed [DUTY_W-1:0] ref_q,
    output logic                     cmd
);

    localparam logic signed [DUTY_W-1:0] LIM_HI = DUTY_W'(PEAK);
    localparam logic signed [DUTY_W-1:0] LIM_LO = -LIM_HI;
    localparam logic signed [EW-1:0]     PEAK_E = EW'(PEAK);

    logic signed [DUTY_W-1:0] duty_clip;
    logic signed [EW-1:0]     lhs, rhs;

    always_comb begin
        if (duty_in > LIM_HI)      duty_clip = LIM_HI;
        else if (duty_in < LIM_LO) duty_clip = LIM_LO;
        else                       duty_clip = duty_in;
    end

    // reference taken only at the carrier valley
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ref_q <= '0;
        else if (at_zero) ref_q <= duty_clip;
    end

    always_comb begin
        lhs = signed'({{(EW - CW - 1){1'b0}}, count, 1'b0});
        rhs = EW'(ref_q) + PEAK_E;
        cmd = (lhs < rhs);
    end

endmodule

// File: rtl/pwm3_deadtime.sv
module pwm3_deadtime
    import pwm3_pkg::*;
#(
    parameter int DEAD = 100,
    localparam int TW = (DEAD > 1) ? $clog2(DEAD) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic cmd,
    output logic gate_hi,
    output logic gate_lo
);

    leg_state_t    state_q, state_d;
    logic          aim_q, aim_d;
    logic [TW-1:0] tmr_q, tmr_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LEG_IDLE;
            aim_q   <= 1'b0;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            aim_q   <= aim_d;
            tmr_q   <= tmr_d;
        end
    end

    // next-state
    always_comb begin
        state_d = state_q;
        aim_d   = aim_q;
        tmr_d   = tmr_q;
        unique case (state_q)
            LEG_IDLE: begin
                if (enable) begin
                    state_d = LEG_GAP;
                    aim_d   = cmd;
                    tmr_d   = '0;
                end
            end
            LEG_GAP: begin
                if (!enable) begin
                    state_d = LEG_IDLE;
                end else if (cmd != aim_q) begin
                    aim_d = cmd;
                    tmr_d = '0;
                end else if (tmr_q == TW'(DEAD - 1)) begin
                    state_d = aim_q ? LEG_HIGH : LEG_LOW;
                end else begin
                    tmr_d = tmr_q + TW'(1);
                end
            end
            LEG_HIGH: begin
                if (!enable) begin
                    state_d = LEG_IDLE;
                end else if (!cmd) begin
                    state_d = LEG_GAP;
                    aim_d   = 1'b0;
                    tmr_d   = '0;
                end
            end
            LEG_LOW: begin
                if (!enable) begin
                    state_d = LEG_IDLE;
                end else if (cmd) begin
                    state_d = LEG_GAP;
                    aim_d   = 1'b1;
                    tmr_d   = '0;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        gate_hi = (state_q == LEG_HIGH);
        gate_lo = (state_q == LEG_LOW);
    end

endmodule

// File: rtl/pwm3_gate_gen.sv
module pwm3_gate_gen
    import pwm3_pkg::*;
#(
    parameter int PEAK   = 5000,
    parameter int DEAD   = 100,
    parameter int DUTY_W = 16,
    localparam int CW    = $clog2(PEAK + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable,
    input  logic signed [DUTY_W-1:0] duty_a,
    input  logic signed [DUTY_W-1:0] duty_b,
    input  logic signed [DUTY_W-1:0] duty_c,
    output logic [NUM_LEGS-1:0]      gate_hi,
    output logic [NUM_LEGS-1:0]      gate_lo
);

    logic [CW-1:0]                          car_cnt;
    logic                                   car_zero;
    logic [NUM_LEGS-1:0][DUTY_W-1:0]        duty_all;
    logic [NUM_LEGS-1:0][DUTY_W-1:0]        ref_all;
    logic [NUM_LEGS-1:0]                    leg_cmd;

    assign duty_all = {duty_c, duty_b, duty_a};

    pwm3_carrier #(.PEAK(PEAK)) u_carrier (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .count   (car_cnt),
        .at_zero (car_zero)
    );

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        logic signed [DUTY_W-1:0] ref_s;

        pwm3_compare #(.PEAK(PEAK), .DUTY_W(DUTY_W), .CW(CW)) u_cmp (
            .clk     (clk),
            .rst_n   (rst_n),
            .at_zero (car_zero),
            .count   (car_cnt),
            .duty_in (signed'(duty_all[g])),
            .ref_q   (ref_s),
            .cmd     (leg_cmd[g])
        );

        assign ref_all[g] = ref_s;

        pwm3_deadtime #(.DEAD(DEAD)) u_dt (
            .clk     (clk),
            .rst_n   (rst_n),
            .enable  (enable),
            .cmd     (leg_cmd[g]),
            .gate_hi (gate_hi[g]),
            .gate_lo (gate_lo[g])
        );
    end

endmodule

// File: rtl/pwm3_gate_chk.sv
module pwm3_gate_chk
    import pwm3_pkg::*;
#(
    parameter int PEAK   = 5000,
    parameter int DEAD   = 100,
    parameter int DUTY_W = 16,
    localparam int CW    = $clog2(PEAK + 1),
    localparam int LW    = $clog2(DEAD + 2)
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              enable,
    input logic [CW-1:0]                     car_cnt,
    input logic [NUM_LEGS-1:0][DUTY_W-1:0]   ref_all,
    input logic [NUM_LEGS-1:0]               gate_hi,
    input logic [NUM_LEGS-1:0]               gate_lo
);

    // R7: pair never overlaps
    p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_hi & gate_lo) == '0);

    // R1: disable forces every gate off after the edge
    p_off_when_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (gate_hi == '0 && gate_lo == '0));

    // R2: carrier range, stepping and parking
    p_carrier_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(car_cnt) <= PEAK);

    p_carrier_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> (int'(car_cnt) == int'($past(car_cnt)) + 1 ||
                    int'(car_cnt) == int'($past(car_cnt)) - 1));

    p_carrier_park_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> car_cnt == '0);

    // R4: references hold away from the valley
    p_ref_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (car_cnt != '0) |=> $stable(ref_all));

    // R8 / R10: a rising gate follows at least DEAD both-off cycles
    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_gap
        logic [LW-1:0] off_run;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     off_run <= '0;
            else if (gate_hi[g] | gate_lo[g]) off_run <= '0;
            else if (off_run != LW'(DEAD))  off_run <= off_run + LW'(1);
        end

        p_guard_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate_hi[g]) |-> off_run == LW'(DEAD));

        p_guard_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate_lo[g]) |-> off_run == LW'(DEAD));
    end

endmodule

bind pwm3_gate_gen pwm3_gate_chk #(
    .PEAK   (PEAK),
    .DEAD   (DEAD),
    .DUTY_W (DUTY_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .car_cnt (car_cnt),
    .ref_all (ref_all),
    .gate_hi (gate_hi),
    .gate_lo (gate_lo)
);

// File: tb/tb_pwm3_gate_gen.sv
module tb_pwm3_gate_gen;

    localparam int PEAK   = 20;
    localparam int DEAD   = 3;
    localparam int DUTY_W = 8;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     enable = 1'b0;
    logic signed [DUTY_W-1:0] duty_a = '0;
    logic signed [DUTY_W-1:0] duty_b = '0;
    logic signed [DUTY_W-1:0] duty_c = '0;
    logic [2:0]               gate_hi;
    logic [2:0]               gate_lo;

    always #10 clk = ~clk;   // 50 MHz

    pwm3_gate_gen #(.PEAK(PEAK), .DEAD(DEAD), .DUTY_W(DUTY_W)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .duty_a  (duty_a),
        .duty_b  (duty_b),
        .duty_c  (duty_c),
        .gate_hi (gate_hi),
        .gate_lo (gate_lo)
    );

    typedef struct {
        logic [2:0] hi;
        logic [2:0] lo;
        string      tag;
    } exp_t;

    exp_t  exp_q[$];
    string cur_req = "R1";
    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    // reference model built from the requirements
    int cnt_m;
    bit up_m;
    int ref_m[3];
    int hrun[3];
    int lrun[3];

    function automatic int clip(input int v);
        if (v > PEAK)  return PEAK;     // R5
        if (v < -PEAK) return -PEAK;
        return v;
    endfunction

    always @(posedge clk) begin
        exp_t it;
        it.hi = '0;
        it.lo = '0;
        if (!rst_n) begin
            cnt_m = 0;
            up_m  = 1'b1;
            for (int i = 0; i < 3; i++) begin
                ref_m[i] = 0;
                hrun[i]  = 0;
                lrun[i]  = 0;
            end
        end else begin
            for (int i = 0; i < 3; i++) begin
                bit c;
                c = (2 * cnt_m < ref_m[i] + PEAK);          // R3
                if (enable && c)  hrun[i] = (hrun[i] > DEAD) ? hrun[i] : hrun[i] + 1;
                else              hrun[i] = 0;
                if (enable && !c) lrun[i] = (lrun[i] > DEAD) ? lrun[i] : lrun[i] + 1;
                else              lrun[i] = 0;
                it.hi[i] = (hrun[i] >= DEAD + 1);             // R8
                it.lo[i] = (lrun[i] >= DEAD + 1);             // R6
            end
            if (cnt_m == 0) begin                            // R4, R11
                ref_m[0] = clip(int'(duty_a));
                ref_m[1] = clip(int'(duty_b));
                ref_m[2] = clip(int'(duty_c));
            end
            if (!enable) begin                               // R2
                cnt_m = 0;
                up_m  = 1'b1;
            end else if (up_m) begin
                cnt_m = cnt_m + 1;
                if (cnt_m == PEAK) up_m = 1'b0;
            end else begin
                cnt_m = cnt_m - 1;
                if (cnt_m == 0) up_m = 1'b1;
            end
        end
        it.tag = cur_req;
        exp_q.push_back(it);
    end

    // monitor: compare away from the active edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_vec++;
            if (gate_hi !== e.hi || gate_lo !== e.lo) begin
                n_bad++;
                $display("FAIL %s: hi=%b lo=%b, expected hi=%b lo=%b at %0t",
                         e.tag, gate_hi, gate_lo, e.hi, e.lo, $time);
            end
            n_vec++;
            if ((gate_hi & gate_lo) !== 3'b000) begin
                n_bad++;
                $display("FAIL R7: overlap hi=%b lo=%b, expected overlap 000",
                         gate_hi, gate_lo);
            end
        end
    end

    task automatic drive(input int a, input int b, input int c, input bit en,
                         input int cycles, input string tag);
        @(posedge clk);
        #1;
        duty_a  = DUTY_W'(a);
        duty_b  = DUTY_W'(b);
        duty_c  = DUTY_W'(c);
        enable  = en;
        cur_req = tag;
        repeat (cycles - 1) @(posedge clk);
    endtask

    initial begin
        // R1: reset state
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        drive(0, 0, 0, 1'b0, 4, "R1 reset/idle");
        // R2 R3 R6 R8 R10 R11: distinct references per leg
        drive(0, 10, -10, 1'b1, 4 * 2 * PEAK, "R2/R3/R6/R8/R10/R11 base");
        // R4: mid-period change waits for the valley
        drive(0, 15, -10, 1'b1, 7, "R4 late update");
        drive(-5, 15, 6, 1'b1, 3 * 2 * PEAK, "R4 late update");
        // R5 and R9: clamped references, one-cycle gaps swallowed
        drive(100, 0, -100, 1'b1, 3 * 2 * PEAK, "R5/R9 clamp");
        // R9: one-cycle high pulse per period is swallowed
        drive(-PEAK + 2, PEAK - 2, 0, 1'b1, 3 * 2 * PEAK, "R9 short pulse");
        // R1 R10: disable mid-run, then resume
        drive(-PEAK + 2, PEAK - 2, 0, 1'b1, 13, "R9 short pulse");
        drive(8, -8, 3, 1'b0, 7, "R1 disable");
        drive(8, -8, 3, 1'b1, 3 * 2 * PEAK, "R10 resume");
        // R3 R11: sweep of references
        for (int s = -PEAK; s <= PEAK; s += 5)
            drive(s, -s, s / 2, 1'b1, 2 * PEAK, "R3/R11 sweep");
        drive(0, 0, 0, 1'b0, 6, "R1 final idle");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule